// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block gathers sixteen active-low interrupt request lines into a pending register and chooses which pending level a downstream sequencer should service next. Each input passes through a two-flop synchronizer. At every cycle-end strobe, the inputs that are due are merged into the pending register. This capture happens whether or not interrupts are globally enabled and whether or not a level is masked. A software-written mask decides which pending levels may raise a request. Level 0 can never be masked. The lowest-numbered eligible level wins and is reported as a 4-bit code.

A per-input sensitivity register chooses between two modes. In level mode, a line held low pends again at every cycle end, including after a service. In edge mode, a high-to-low transition is remembered until the next cycle end, and the line must go high again before it can produce another request. Two inputs, chosen by a parameter, always behave as level mode.

When the sequencer starts a service, it strobes the serviced level into the block. That level's pending bit is cleared, and a one-cycle active-low acknowledge is returned carrying the same level code.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After synchronous reset: pending, mask and sensitivity registers are all zero (level mode for every input), the request is low and the acknowledge output is high.
- R2: In level mode, an input that has been low for at least three clock edges is set in the pending register at the rising edge where the cycle-end strobe is high. Pending bit i corresponds to level i.
- R3: Capture into the pending register takes place regardless of the global enable and of the mask. Pending bits only clear through a service.
- R4: A level is eligible only when its mask bit (bit i for level i) is 1. A masked pending level stays pending and requests once its mask bit is written to 1.
- R5: Level 0 is eligible whenever it is pending, whatever mask bit 0 holds.
- R6: The request output is high exactly when the global enable is high and at least one level is eligible. The level output then gives the lowest-numbered eligible level, so level 0 has the highest priority.
- R7: In edge mode (sensitivity bit i = 1), one high-to-low transition pends the level once. A line held low does not pend again after service until it has returned high and fallen again.
- R8: In level mode, a line still held low pends again at the first cycle end after its service.
- R9: The level-only inputs (levels 12 and 13 by default) ignore their sensitivity bits and always act in level mode.
- R10: A service strobe drives the acknowledge low for exactly the next cycle, with the acknowledge level equal to the serviced level.
- R11: A service clears the serviced level's pending bit at the same edge. If a capture sets that bit at the same edge, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 16 | Active-low request lines, bit i is level i |
| cyc_end | input | 1 | End-of-cycle strobe that loads the pending register |
| int_en | input | 1 | Global interrupt enable |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 16 | Mask write data, 1 = enabled |
| cfg_we | input | 1 | Sensitivity register write strobe |
| cfg_wdata | input | 16 | Sensitivity write data, 1 = edge mode |
| svc_stb | input | 1 | Service start strobe |
| svc_lvl | input | 4 | Level being serviced |
| req | output | 1 | Interrupt request to the sequencer |
| req_lvl | output | 4 | Highest-priority eligible level |
| ack_n | output | 1 | Active-low service acknowledge |
| ack_lvl | output | 4 | Level code carried with the acknowledge |
| pend | output | 16 | Pending register |
| mask | output | 16 | Mask register |

## Verification
The assertions assume that the service strobe lasts one cycle and that the sequencer only services a level it has seen requested. The stickiness check also assumes that pending bits change only through capture or service. The stimulus respects these assumptions: every service strobe is a single-cycle pulse naming a pending level, and inputs are held for at least three edges before a cycle end, so the synchronizer delay never overlaps a capture.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IRQ_N = 16;
    localparam int LVL_W = $clog2(IRQ_N);

    typedef logic [IRQ_N-1:0] irq_vec_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic valid;
        lvl_t lvl;
    } pick_t;

    // lowest index wins
    function automatic pick_t pick_first(irq_vec_t v);
        pick_t p;
        p.valid = 1'b0;
        p.lvl   = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.lvl   = lvl_t'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_n,
    output logic [W-1:0] sync_n,
    output logic [W-1:0] fall
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic s1_q, s2_q, prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q   <= 1'b1;
                s2_q   <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                s1_q   <= raw_n[g];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end
        assign sync_n[g] = s2_q;
        assign fall[g]   = prev_q & ~s2_q;
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_pkg::*;
(
    input  irq_vec_t pend,
    input  irq_vec_t mask,
    input  logic     en,
    output logic     req,
    output lvl_t     lvl
);
    irq_vec_t elig;
    pick_t    sel;

    always_comb begin
        elig = pend & (mask | irq_vec_t'(1));
        sel  = pick_first(elig);
        req  = en & sel.valid;
        lvl  = sel.lvl;
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pkg::*;
#(
    parameter irq_vec_t LVL_ONLY = 16'h3000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_N-1:0] irq_n,
    input  logic             cyc_end,
    input  logic             int_en,
    input  logic             mask_we,
    input  logic [IRQ_N-1:0] mask_wdata,
    input  logic             cfg_we,
    input  logic [IRQ_N-1:0] cfg_wdata,
    input  logic             svc_stb,
    input  logic [LVL_W-1:0] svc_lvl,
    output logic             req,
    output logic [LVL_W-1:0] req_lvl,
    output logic             ack_n,
    output logic [LVL_W-1:0] ack_lvl,
    output logic [IRQ_N-1:0] pend,
    output logic [IRQ_N-1:0] mask
);
    irq_vec_t sync_n, fall;
    irq_vec_t pend_q, mask_q, cfg_q, edge_q;
    irq_vec_t edge_mode, hit, svc_clr, pend_d;
    logic     ack_q;
    lvl_t     ack_lvl_q;

    irq_in_sync #(.W(IRQ_N)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw_n  (irq_n),
        .sync_n (sync_n),
        .fall   (fall)
    );

    always_comb begin
        edge_mode = cfg_q & ~LVL_ONLY;
        hit       = (edge_mode & (edge_q | fall)) | (~edge_mode & ~sync_n);
        svc_clr   = svc_stb ? (irq_vec_t'(1) << svc_lvl) : '0;
        pend_d    = (pend_q & ~svc_clr) | (cyc_end ? hit : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            mask_q    <= '0;
            cfg_q     <= '0;
            edge_q    <= '0;
            ack_q     <= 1'b0;
            ack_lvl_q <= '0;
        end else begin
            pend_q    <= pend_d;
            edge_q    <= cyc_end ? '0 : (edge_q | fall);
            ack_q     <= svc_stb;
            ack_lvl_q <= svc_stb ? svc_lvl : ack_lvl_q;
            if (mask_we) mask_q <= mask_wdata;
            if (cfg_we)  cfg_q  <= cfg_wdata;
        end
    end

    irq_prio_enc enc_i (
        .pend (pend_q),
        .mask (mask_q),
        .en   (int_en),
        .req  (req),
        .lvl  (req_lvl)
    );

    assign ack_n   = ~ack_q;
    assign ack_lvl = ack_lvl_q;
    assign pend    = pend_q;
    assign mask    = mask_q;

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        svc_stb |=> (!ack_n && ack_lvl == $past(svc_lvl)));
    p_ack_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !svc_stb |=> ack_n);
    p_req_gated_r6: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !req);
    p_req_pending_r4: assert property (@(posedge clk) disable iff (rst)
        req |-> (pend[req_lvl] && (mask[req_lvl] || req_lvl == '0)));
    p_lvl0_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (int_en && pend[0]) |-> (req && req_lvl == '0));
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !svc_stb |=> (($past(pend) & ~pend) == '0));
    p_svc_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (svc_stb && !cyc_end) |=> !pend[$past(svc_lvl)]);
endmodule

// File: tb/irq_pend_ctrl_tb_top.sv
module irq_pend_ctrl_tb_top;
    import irq_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] irq_n = '1;
    logic cyc_end = 1'b0, int_en = 1'b0, mask_we = 1'b0, cfg_we = 1'b0, svc_stb = 1'b0;
    logic [15:0] mask_wdata = '0, cfg_wdata = '0;
    logic [3:0] svc_lvl = '0;
    logic req, ack_n;
    logic [3:0] req_lvl, ack_lvl;
    logic [15:0] pend, mask;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pend_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_n(irq_n), .cyc_end(cyc_end), .int_en(int_en),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .svc_stb(svc_stb), .svc_lvl(svc_lvl), .req(req), .req_lvl(req_lvl),
        .ack_n(ack_n), .ack_lvl(ack_lvl), .pend(pend), .mask(mask)
    );

    typedef struct packed {
        logic [15:0] low;
        logic [15:0] msk;
        logic        en;
        logic        ereq;
        logic [3:0]  elvl;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{16'h0090, 16'hFFFF, 1'b1, 1'b1, 4'd4},
        '{16'h0090, 16'hFFEF, 1'b1, 1'b1, 4'd7},
        '{16'h0090, 16'h0000, 1'b1, 1'b0, 4'd0},
        '{16'h0091, 16'h0000, 1'b1, 1'b1, 4'd0},
        '{16'h8000, 16'hFFFF, 1'b0, 1'b0, 4'd0},
        '{16'hFFFF, 16'hFFFE, 1'b1, 1'b1, 4'd0},
        '{16'h8002, 16'h8000, 1'b1, 1'b1, 4'd15}
    };

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        irq_n = '1; rst = 1'b1; step(2); rst = 1'b0;
    endtask

    task automatic capture();
        step(3); cyc_end = 1'b1; step(1); cyc_end = 1'b0;
    endtask

    task automatic wr_mask(logic [15:0] m);
        mask_wdata = m; mask_we = 1'b1; step(1); mask_we = 1'b0;
    endtask

    task automatic wr_cfg(logic [15:0] c);
        cfg_wdata = c; cfg_we = 1'b1; step(1); cfg_we = 1'b0;
    endtask

    task automatic service(logic [3:0] l, logic with_cyc);
        svc_lvl = l; svc_stb = 1'b1; cyc_end = with_cyc; step(1);
        svc_stb = 1'b0; cyc_end = 1'b0;
    endtask

    initial begin
        step(1);
        rst = 1'b1; step(2); rst = 1'b0; step(1);
        // R1 reset state
        chk("R1 pend", pend, 0);
        chk("R1 mask", mask, 0);
        chk("R1 req", req, 0);
        chk("R1 ack_n", ack_n, 1);

        // Table walk: R2 R3 R4 R5 R6
        for (int k = 0; k < 7; k++) begin
            do_reset();
            wr_mask(TBL[k].msk);
            int_en = TBL[k].en;
            irq_n = ~TBL[k].low;
            capture();
            irq_n = '1;
            chk("R2 R3 pend captured", pend, TBL[k].low);
            chk("R6 req", req, TBL[k].ereq);
            if (TBL[k].ereq) chk("R6 R4 R5 req_lvl", req_lvl, TBL[k].elvl);
        end

        // R4 masked then unmasked
        do_reset(); int_en = 1'b1;
        irq_n = ~16'h0020; capture(); irq_n = '1;
        chk("R4 masked no req", req, 0);
        wr_mask(16'h0020);
        chk("R4 unmasked req", req, 1);
        chk("R4 unmasked lvl", req_lvl, 5);

        // R10 ack pulse and R11 clear
        service(4'd5, 1'b0);
        chk("R10 ack low", ack_n, 0);
        chk("R10 ack lvl", ack_lvl, 5);
        chk("R11 cleared", pend[5], 0);
        step(1);
        chk("R10 ack one cycle", ack_n, 1);

        // R7 edge mode
        do_reset(); wr_cfg(16'h0080); wr_mask('1); int_en = 1'b1;
        irq_n = ~16'h0080; capture();
        chk("R7 edge pends", pend[7], 1);
        service(4'd7, 1'b0);
        capture();
        chk("R7 held low no repend", pend[7], 0);
        irq_n = '1; step(3);
        irq_n = ~16'h0080; capture();
        chk("R7 new fall pends", pend[7], 1);
        irq_n = '1;

        // R8 level re-pend
        do_reset(); wr_mask('1); int_en = 1'b1;
        irq_n = ~16'h0200; capture();
        service(4'd9, 1'b0);
        chk("R8 cleared by service", pend[9], 0);
        capture();
        chk("R8 level repends", pend[9], 1);

        // R11 capture beats clear; clear wins when line idle
        service(4'd9, 1'b1);
        chk("R11 capture wins", pend[9], 1);
        irq_n = '1; step(3);
        service(4'd9, 1'b1);
        chk("R11 clear when idle", pend[9], 0);

        // R9 level-only input ignores edge config
        do_reset(); wr_cfg('1); wr_mask('1);
        irq_n = ~16'h1000; capture();
        service(4'd12, 1'b0);
        capture();
        chk("R9 level-only repends", pend[12], 1);
        irq_n = '1;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule